// File: doc/BRIEF.md
# Chained-Residual Hebbian Weight Updater

This block performs one training step of a generalized Hebbian learner that extracts principal components. It receives an input vector of M signed fixed-point samples, the L neuron outputs already computed for that input, and the L current weight vectors of M elements each. It returns the L adapted weight vectors. Neuron j subtracts its own contribution from the residual that neuron j-1 left behind. Neuron 0 starts from the raw input. Each neuron therefore reuses the partial sum of all earlier neurons instead of forming that sum again.

The array holds L stages of M identical cells. Every cell stores one weight and one residual element. A sequencer lets stage j form its residual in step j and apply its weight change in step j+1. That second step is the same clock in which stage j+1 forms its residual. A complete update is therefore ready L+1 clocks after the start is accepted. The learning rate is a power of two, applied as an arithmetic right shift. A caller loads a new vector set with a one-clock `start` and waits for `done`.

Top module: `hebb_update`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are low and every element of `w_vec` is zero.
- R2: Residuals chain across neurons. For neuron 0, z = sat(x_i − mul(w_0i, y_0)). For neuron j > 0, z = sat(z_(j−1)i − mul(w_ji, y_j)).
- R3: Each new weight is w_ji + (mul(y_j, z_ji) >>> shift), saturated to 16 bits. It uses the weight value that was loaded at start.
- R4: mul(a, b) on two signed Q1.15 values forms the 32-bit product, adds 2^14, arithmetically shifts right by 15, and saturates to [−32768, 32767]. Therefore (−1)·(−1) gives 32767.
- R5: Every addition and subtraction saturates to [−32768, 32767] instead of wrapping.
- R6: `done` is high for exactly one clock. It is registered L+1 rising edges after the edge that accepts `start`.
- R7: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `busy` is low while `done` is high.
- R8: A `start` while `busy` is high is ignored. New data on the inputs at that time changes neither the timing nor the result.
- R9: After `done`, `w_vec` holds the result until the next accepted `start`.
- R10: `shift_amt` takes 0 to 15. The shift is arithmetic, so negative steps round toward minus infinity. The value is captured when `start` is accepted.
- R11: A `start` in the same clock as `done` is accepted and begins a new update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load inputs and begin an update (accepted when not busy) |
| shift_amt | input | 4 | Learning-rate right shift, 0..15 |
| x_vec | input | M*16 | Input vector, element i at bits [16i+15:16i] |
| y_vec | input | L*16 | Neuron outputs, neuron j at bits [16j+15:16j] |
| w_init | input | L*M*16 | Current weights, element (j,i) at bits [16(jM+i)+15:16(jM+i)] |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-clock pulse: all new weights valid |
| w_vec | output | L*M*16 | Weight array, same layout as `w_init` |

## Verification
The bench drives `start` half a clock before the accepting edge. It then samples at every following falling edge k. After edge k, `busy` must be high for k = 0..L and low at k = L+1. `done` must be high only at k = L+1, which is the sample where the weights are also compared against a behavioural model. The weights are compared again in the idle cycles after that sample to confirm they hold. Two more cases keep the same cycle count. A second `start` carrying other data at k = 0 must leave both the result and the `done` sample unchanged. A `start` raised at the `done` sample must make `busy` high at the very next sample.

// File: rtl/hebb_pkg.sv
package hebb_pkg;

    localparam int DW   = 16;
    localparam int SH_W = $clog2(DW);

    typedef logic signed [DW-1:0] q15_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic load;
        logic res_en;
        logic upd_en;
    } stage_ctl_t;

    function automatic q15_t sat16(input logic signed [33:0] v);
        if (v > 34'sd32767)
            return 16'sh7fff;
        else if (v < -34'sd32768)
            return 16'sh8000;
        else
            return v[15:0];
    endfunction

    function automatic q15_t q_mul(input q15_t a, input q15_t b);
        logic signed [31:0] p;
        logic signed [33:0] r;
        p = a * b;
        r = (34'(p) + 34'sd16384) >>> 15;
        return sat16(r);
    endfunction

    function automatic q15_t q_add(input q15_t a, input q15_t b);
        return sat16(34'(a) + 34'(b));
    endfunction

    function automatic q15_t q_sub(input q15_t a, input q15_t b);
        return sat16(34'(a) - 34'(b));
    endfunction

    function automatic q15_t q_shr(input q15_t v, input logic [SH_W-1:0] s);
        return v >>> s;
    endfunction

endpackage

// File: rtl/hebb_ctrl.sv
module hebb_ctrl
    import hebb_pkg::*;
#(
    parameter int L = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic         load,
    output logic         busy,
    output logic         done,
    output logic [L-1:0] res_en,
    output logic [L-1:0] upd_en
);
    localparam int SW = $clog2(L + 1);

    ctl_state_t     st;
    logic [SW-1:0]  step;

    assign busy = (st == ST_RUN);
    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            step <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                st   <= ST_RUN;
                step <= '0;
            end else if (busy) begin
                if (step == SW'(L)) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end else begin
                    step <= step + SW'(1);
                end
            end
        end
    end

    // Stage j forms its residual in step j, updates its weight in step j+1
    for (genvar j = 0; j < L; j++) begin : g_dec
        assign res_en[j] = busy && (step == SW'(j));
        assign upd_en[j] = busy && (step == SW'(j + 1));
    end

    // Independent cycle counter from the accepting edge, for the latency check
    logic [15:0] obs_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            obs_cnt <= 16'hffff;
        else if (load)
            obs_cnt <= '0;
        else if (obs_cnt != 16'hffff)
            obs_cnt <= obs_cnt + 16'd1;
    end

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (obs_cnt == 16'(L + 1)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (step != SW'(L))) |=> (busy && (step == $past(step) + SW'(1))));

endmodule

// File: rtl/hebb_cell.sv
module hebb_cell
    import hebb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  stage_ctl_t      ctl,
    input  logic [SH_W-1:0] shamt,
    input  q15_t            y_val,
    input  q15_t            z_prev,
    input  q15_t            w_load,
    output q15_t            z_out,
    output q15_t            w_out
);
    q15_t z_q;
    q15_t w_q;

    q15_t corr;
    q15_t step_v;

    assign corr   = q_mul(w_q, y_val);
    assign step_v = q_shr(q_mul(y_val, z_q), shamt);

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q <= '0;
            w_q <= '0;
        end else begin
            if (ctl.load)
                w_q <= w_load;
            else if (ctl.upd_en)
                w_q <= q_add(w_q, step_v);
            if (ctl.res_en)
                z_q <= q_sub(z_prev, corr);
        end
    end

    assign z_out = z_q;
    assign w_out = w_q;

    // R3
    weight_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.upd_en) |=> $stable(w_out));

    // R2
    res_update_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.res_en && ctl.upd_en));

endmodule

// File: rtl/hebb_stage.sv
module hebb_stage
    import hebb_pkg::*;
#(
    parameter int M = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_ctl_t       ctl,
    input  logic [SH_W-1:0]  shamt,
    input  q15_t             y_val,
    input  q15_t [M-1:0]     z_prev,
    input  q15_t [M-1:0]     w_load,
    output q15_t [M-1:0]     z_out,
    output q15_t [M-1:0]     w_out
);
    for (genvar i = 0; i < M; i++) begin : g_cell
        hebb_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .shamt  (shamt),
            .y_val  (y_val),
            .z_prev (z_prev[i]),
            .w_load (w_load[i]),
            .z_out  (z_out[i]),
            .w_out  (w_out[i])
        );
    end

endmodule

// File: rtl/hebb_update.sv
module hebb_update
    import hebb_pkg::*;
#(
    parameter int M = 4,
    parameter int L = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        shift_amt,
    input  logic [M*16-1:0]   x_vec,
    input  logic [L*16-1:0]   y_vec,
    input  logic [L*M*16-1:0] w_init,
    output logic              busy,
    output logic              done,
    output logic [L*M*16-1:0] w_vec
);
    localparam int VW = M * DW;

    logic         load;
    logic [L-1:0] res_en;
    logic [L-1:0] upd_en;

    q15_t [M-1:0]    x_q;
    q15_t [L-1:0]    y_q;
    logic [SH_W-1:0] sh_q;

    q15_t [M-1:0] z_in    [L];
    q15_t [M-1:0] z_chain [L];
    q15_t [M-1:0] w_stage [L];

    hebb_ctrl #(.L(L)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .load   (load),
        .busy   (busy),
        .done   (done),
        .res_en (res_en),
        .upd_en (upd_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q  <= '0;
            y_q  <= '0;
            sh_q <= '0;
        end else if (load) begin
            x_q  <= x_vec;
            y_q  <= y_vec;
            sh_q <= shift_amt;
        end
    end

    for (genvar j = 0; j < L; j++) begin : g_stage
        stage_ctl_t ctl_j;
        assign ctl_j = '{load: load, res_en: res_en[j], upd_en: upd_en[j]};

        if (j == 0) begin : g_first
            assign z_in[j] = x_q;
        end else begin : g_next
            assign z_in[j] = z_chain[j-1];
        end

        hebb_stage #(.M(M)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl_j),
            .shamt  (sh_q),
            .y_val  (y_q[j]),
            .z_prev (z_in[j]),
            .w_load (w_init[j*VW +: VW]),
            .z_out  (z_chain[j]),
            .w_out  (w_stage[j])
        );

        assign w_vec[j*VW +: VW] = w_stage[j];
    end

    // R2
    res_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(res_en));

    // R3
    upd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_en));

    // R2
    last_res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res_en[L-1] |=> $stable(z_chain[L-1]));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> $stable(w_vec));

endmodule

// File: tb/hebb_update_tb_top.sv
module hebb_update_tb_top;
    localparam int M = 4;
    localparam int L = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [3:0]        shift_amt;
    logic [M*16-1:0]   x_vec;
    logic [L*16-1:0]   y_vec;
    logic [L*M*16-1:0] w_init;
    logic              busy;
    logic              done;
    logic [L*M*16-1:0] w_vec;

    always #2 clk = ~clk;

    hebb_update #(.M(M), .L(L)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .shift_amt (shift_amt),
        .x_vec     (x_vec),
        .y_vec     (y_vec),
        .w_init    (w_init),
        .busy      (busy),
        .done      (done),
        .w_vec     (w_vec)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    int xv [M];
    int yv [L];
    int wv [L][M];
    int sh;
    int ew [L][M];

    function automatic int sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int mulq(input int a, input int b);
        longint p;
        p = longint'(a) * longint'(b);
        return sat((p + 16384) >>> 15);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model();
        int z [M];
        for (int j = 0; j < L; j++) begin
            for (int i = 0; i < M; i++) begin
                int zp;
                zp = (j == 0) ? xv[i] : z[i];
                z[i] = sat(longint'(zp) - mulq(wv[j][i], yv[j]));
                ew[j][i] = sat(longint'(wv[j][i]) + (mulq(yv[j], z[i]) >>> sh));
            end
        end
    endtask

    task automatic drive_ports();
        for (int i = 0; i < M; i++) x_vec[i*16 +: 16] = 16'(xv[i]);
        for (int j = 0; j < L; j++) begin
            y_vec[j*16 +: 16] = 16'(yv[j]);
            for (int i = 0; i < M; i++) w_init[(j*M+i)*16 +: 16] = 16'(wv[j][i]);
        end
        shift_amt = 4'(sh);
    endtask

    task automatic gen(input int kind, input int s);
        sh = s;
        for (int i = 0; i < M; i++)
            xv[i] = (kind == 1) ? -32768 : int'($urandom_range(0, 65535)) - 32768;
        for (int j = 0; j < L; j++) begin
            yv[j] = (kind == 1) ? -32768 : int'($urandom_range(0, 65535)) - 32768;
            for (int i = 0; i < M; i++)
                wv[j][i] = (kind == 1) ? -32768 : int'($urandom_range(0, 65535)) - 32768;
        end
    endtask

    task automatic check_weights(input string req);
        for (int j = 0; j < L; j++)
            for (int i = 0; i < M; i++) begin
                int a;
                a = int'($signed(w_vec[(j*M+i)*16 +: 16]));
                check(a == ew[j][i], req, a, ew[j][i]);
            end
    endtask

    // pre: start already driven; inject: second start while busy; chain: start at done
    task automatic run(input bit pre, input bit inject, input bit chain, input string req);
        model();
        if (!pre) begin
            @(negedge clk);
            drive_ports();
            start = 1'b1;
        end
        for (int k = 0; k <= L + 1; k++) begin
            @(negedge clk);
            start = 1'b0;
            check(busy == (k <= L), "R7 busy", busy, k <= L);
            check(done == (k == L + 1), "R6 done", done, k == L + 1);
            if (inject && k == 0) begin
                for (int i = 0; i < M; i++) x_vec[i*16 +: 16] = 16'h4000;
                w_init = '1;
                shift_amt = 4'd0;
                start = 1'b1;
            end
            if (k == L + 1) begin
                check_weights(req);
                if (chain) begin
                    gen(0, 3);
                    drive_ports();
                    start = 1'b1;
                end
            end
        end
    endtask

    task automatic hold_check(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check(!done && !busy, "R9 idle", {busy, done}, 0);
            check_weights("R9 hold");
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        rst = 1'b1;
        start = 1'b0;
        shift_amt = '0;
        x_vec = '0;
        y_vec = '0;
        w_init = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 flags", {busy, done}, 0);
        check(w_vec == '0, "R1 weights", w_vec != '0, 0);

        // R2 R3 main function, shift 0
        gen(0, 0);
        run(0, 0, 0, "R2 R3 shift0");
        hold_check(3);

        // R4 R5 saturation corner: all -1
        gen(1, 0);
        run(0, 0, 0, "R4 R5 saturation");

        // R10 maximum shift and a mid shift
        gen(0, 15);
        run(0, 0, 0, "R10 shift15");
        gen(0, 7);
        run(0, 0, 0, "R10 shift7");

        // R8 start while busy ignored
        gen(0, 2);
        run(0, 1, 0, "R8 ignored start");
        hold_check(2);

        // R11 back-to-back start at done
        gen(0, 1);
        run(0, 0, 1, "R11 first");
        run(1, 0, 0, "R11 chained");

        for (int t = 0; t < 6; t++) begin
            gen(0, t * 2);
            run(0, 0, 0, "R3 random");
        end
        hold_check(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule